// File: doc/BRIEF.md
# Dual Timer with Capture/Reload

This block is a general-purpose timing unit with two 16-bit counters and one shared 16-bit capture/reload register. The core timer and the auxiliary timer each count one of three sources. The first is the system clock divided by a programmable factor. The second is rising edges on a dedicated count pin. The third, for the auxiliary timer only, is the wraps of the core timer. Each timer counts up or down under a software bit. A direction pin can invert that bit while the timer runs.

A wrap of the core timer does several things. It inverts a toggle latch driven on `tog_out`. It raises a one-cycle `ovf_out` pulse for an external compare timer. It can reload the core timer from the shared register. It can advance the auxiliary timer, so the two timers form one long counter. An edge on the capture pin copies the auxiliary count into the shared register. The edge can instead come from the count or direction line of a third timer. The capture can also clear the auxiliary timer. With clearing on, the register holds the period between edges, which gives edge-to-edge timing, and the core timer reloaded from it gives pulse multiplication.

Software reaches six registers through a single-cycle write strobe and a combinational read port. Three sticky event flags drive `irq`.

Top module: `dtcr_top`

## Requirements
- R1: A timer fed by the divided clock with divide code c (bits 2:0 of its control word, at address 0 for the core timer and 1 for the auxiliary timer) advances once every 4<<c clock cycles. It holds when its run bit (bit 7) is 0. The source field is bits 4:3: 0 = divided clock, 1 = count pin, 2 = core wraps.
- R2: Bit 5 of the control word set to 1 makes the timer count down. When bit 6 is set, a high level on the timer's direction pin inverts the counting direction. When bit 6 is clear, the pin has no effect.
- R3: When the core timer wraps (FFFFh to 0000h going up, or 0000h to FFFFh going down), `ovf_out` pulses for one cycle, `tog_out` inverts, and flag bit 0 (address 5) is set.
- R4: When reload is enabled (core control bit 8), a core wrap loads the core timer from the capture/reload register (address 4) instead of wrapping.
- R5: With source 2, the auxiliary timer advances by one on each core wrap.
- R6: With source 1, a timer advances once per rising edge on its count pin. The pin passes through a two-stage synchroniser.
- R7: Auxiliary control bits 10:9 select the capture edge: 0 = none, 1 = rising, 2 = falling, 3 = both. On a selected edge, the auxiliary count is copied into address 4 and flag bit 2 is set. Edges that are not selected are ignored.
- R8: When auxiliary control bit 12 is set, a capture clears the auxiliary timer in the same cycle.
- R9: When auxiliary control bit 11 is set, the capture edge is taken from either third-timer line (count or direction) instead of the capture pin. The capture pin is then ignored.
- R10: The flags (bits 2:0 at address 5: core wrap, auxiliary wrap, capture) stay set until software writes 0 to them. Writing 1 to a flag leaves it unchanged.
- R11: If a capture and a software write to address 4 occur in the same cycle, the captured value is stored.
- R12: After reset, all registers, counters, flags and `tog_out` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the addressed register |
| core_cnt_in | input | 1 | Core timer count pin |
| core_dir_in | input | 1 | Core timer direction pin |
| aux_cnt_in | input | 1 | Auxiliary timer count pin |
| aux_dir_in | input | 1 | Auxiliary timer direction pin |
| cap_in | input | 1 | Capture pin |
| ext_cnt_in | input | 1 | Third-timer count line, an alternative capture source |
| ext_dir_in | input | 1 | Third-timer direction line, an alternative capture source |
| tog_out | output | 1 | Core toggle latch |
| ovf_out | output | 1 | One-cycle pulse on each core wrap |
| irq | output | 3 | Sticky flags: core wrap, auxiliary wrap, capture |

## Verification
The hardest situation to reach is a capture and a software write to the shared register landing on the same clock edge. The capture pin first passes through a synchroniser and an edge detector. The bench counts those three register stages and raises the pin exactly two cycles before it issues the write, so both requests meet at one edge. The running counters are checked without knowing the prescaler phase. The bench reads a start value and waits a whole multiple of the divide factor, so the number of ticks is fixed. It then derives the expected count, including wraps and reloads, from a model of the requirements.

// File: rtl/dtcr_pkg.sv
package dtcr_pkg;

    localparam int PRE_BITS = 3;

    typedef enum logic [1:0] {
        SRC_PRESC = 2'd0,
        SRC_PIN   = 2'd1,
        SRC_CHAIN = 2'd2,
        SRC_OFF   = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        A_CORE_CTL = 3'd0,
        A_AUX_CTL  = 3'd1,
        A_CORE_CNT = 3'd2,
        A_AUX_CNT  = 3'd3,
        A_CAPREL   = 3'd4,
        A_FLAGS    = 3'd5
    } addr_e;

    typedef struct packed {
        logic                clr_on_cap;
        logic                cap_src;
        logic [1:0]          cap_edge;
        logic                reload;
        logic                run;
        logic                pin_dir_en;
        logic                down;
        src_e                src;
        logic [PRE_BITS-1:0] pre;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/dtcr_sync_edge.sv
module dtcr_sync_edge #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = din;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign lvl[i]  = st_q.s2[i];
        assign rise[i] = st_q.s2[i] & ~st_q.prev[i];
        assign fall[i] = ~st_q.s2[i] & st_q.prev[i];
    end

endmodule

// File: rtl/dtcr_counter.sv
module dtcr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         down,
    input  logic         wr,
    input  logic [W-1:0] wval,
    input  logic         clr,
    input  logic         reload,
    input  logic [W-1:0] rval,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    logic [W-1:0] cnt_d, cnt_q;

    assign wrap = tick & (down ? (cnt_q == '0) : (&cnt_q));
    assign cnt  = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (wr) begin
            cnt_d = wval;
        end else if (clr) begin
            cnt_d = '0;
        end else if (tick) begin
            if (wrap && reload) cnt_d = rval;
            else if (down)      cnt_d = cnt_q - W'(1);
            else                cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr && !clr) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/dtcr_top.sv
module dtcr_top
    import dtcr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic         core_cnt_in,
    input  logic         core_dir_in,
    input  logic         aux_cnt_in,
    input  logic         aux_dir_in,
    input  logic         cap_in,
    input  logic         ext_cnt_in,
    input  logic         ext_dir_in,
    output logic         tog_out,
    output logic         ovf_out,
    output logic [2:0]   irq
);

    localparam int PW  = (1 << PRE_BITS) + 1;
    localparam int NIN = 7;

    typedef struct packed {
        ctl_t          core_ctl;
        ctl_t          aux_ctl;
        logic [W-1:0]  caprel;
        logic [2:0]    flags;
        logic          tog;
        logic [PW-1:0] pre;
    } st_t;

    st_t st_d, st_q;

    logic [NIN-1:0] pin_lvl, pin_rise, pin_fall;
    logic [W-1:0]   core_cnt, aux_cnt;
    logic           core_wrap, aux_wrap;
    logic           core_tick, aux_tick, core_down, aux_down;
    logic           core_wr, aux_wr, cap_wr, cap_evt;
    logic           sel_rise, sel_fall;

    // pin order: 0 core cnt, 1 core dir, 2 aux cnt, 3 aux dir, 4 cap, 5 ext cnt, 6 ext dir
    dtcr_sync_edge #(.N(NIN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ext_dir_in, ext_cnt_in, cap_in, aux_dir_in, aux_cnt_in, core_dir_in, core_cnt_in}),
        .lvl  (pin_lvl),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    logic unused_pins;
    assign unused_pins = ^{pin_lvl[6:4], pin_lvl[2], pin_lvl[0],
                           pin_rise[3], pin_rise[1], pin_fall[3:0]};

    function automatic logic pre_hit(input logic [PW-1:0] cnt, input logic [PRE_BITS-1:0] code);
        logic [PW-1:0] m;
        m = (PW'(4) << code) - PW'(1);
        return (cnt & m) == m;
    endfunction

    always_comb begin
        core_tick = 1'b0;
        if (st_q.core_ctl.run) begin
            case (st_q.core_ctl.src)
                SRC_PRESC: core_tick = pre_hit(st_q.pre, st_q.core_ctl.pre);
                SRC_PIN:   core_tick = pin_rise[0];
                default:   core_tick = 1'b0;
            endcase
        end
    end

    always_comb begin
        aux_tick = 1'b0;
        if (st_q.aux_ctl.run) begin
            case (st_q.aux_ctl.src)
                SRC_PRESC: aux_tick = pre_hit(st_q.pre, st_q.aux_ctl.pre);
                SRC_PIN:   aux_tick = pin_rise[2];
                SRC_CHAIN: aux_tick = core_wrap;
                default:   aux_tick = 1'b0;
            endcase
        end
    end

    assign core_down = st_q.core_ctl.down ^ (st_q.core_ctl.pin_dir_en & pin_lvl[1]);
    assign aux_down  = st_q.aux_ctl.down  ^ (st_q.aux_ctl.pin_dir_en  & pin_lvl[3]);

    assign core_wr = wr_en && (addr == A_CORE_CNT);
    assign aux_wr  = wr_en && (addr == A_AUX_CNT);
    assign cap_wr  = wr_en && (addr == A_CAPREL);

    assign sel_rise = st_q.aux_ctl.cap_src ? (pin_rise[5] | pin_rise[6]) : pin_rise[4];
    assign sel_fall = st_q.aux_ctl.cap_src ? (pin_fall[5] | pin_fall[6]) : pin_fall[4];
    assign cap_evt  = (st_q.aux_ctl.cap_edge[0] & sel_rise) | (st_q.aux_ctl.cap_edge[1] & sel_fall);

    dtcr_counter #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(core_tick), .down(core_down),
        .wr(core_wr), .wval(wdata), .clr(1'b0), .reload(st_q.core_ctl.reload),
        .rval(st_q.caprel), .cnt(core_cnt), .wrap(core_wrap)
    );

    dtcr_counter #(.W(W)) u_aux (
        .clk(clk), .rst_n(rst_n), .tick(aux_tick), .down(aux_down),
        .wr(aux_wr), .wval(wdata), .clr(cap_evt & st_q.aux_ctl.clr_on_cap), .reload(1'b0),
        .rval(st_q.caprel), .cnt(aux_cnt), .wrap(aux_wrap)
    );

    always_comb begin
        st_d     = st_q;
        st_d.pre = st_q.pre + PW'(1);
        st_d.tog = st_q.tog ^ core_wrap;
        if (wr_en) begin
            case (addr)
                A_CORE_CTL: st_d.core_ctl = ctl_t'(wdata[CTL_W-1:0]);
                A_AUX_CTL:  st_d.aux_ctl  = ctl_t'(wdata[CTL_W-1:0]);
                A_CAPREL:   st_d.caprel   = wdata;
                A_FLAGS:    st_d.flags    = st_q.flags & wdata[2:0];
                default:    ;
            endcase
        end
        if (cap_evt) st_d.caprel = aux_cnt;
        st_d.flags = st_d.flags | {cap_evt, aux_wrap, core_wrap};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr)
            A_CORE_CTL: rdata = W'(st_q.core_ctl);
            A_AUX_CTL:  rdata = W'(st_q.aux_ctl);
            A_CORE_CNT: rdata = core_cnt;
            A_AUX_CNT:  rdata = aux_cnt;
            A_CAPREL:   rdata = st_q.caprel;
            A_FLAGS:    rdata = W'(st_q.flags);
            default:    rdata = '0;
        endcase
    end

    assign tog_out = st_q.tog;
    assign ovf_out = core_wrap;
    assign irq     = st_q.flags;

    // R3
    wrap_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_wrap |=> (tog_out != $past(tog_out)));

    // R3
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_out |=> irq[0]);

    // R4
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wrap && st_q.core_ctl.reload && !core_wr) |=> (core_cnt == $past(st_q.caprel)));

    // R7
    capture_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (st_q.caprel == $past(aux_cnt)) && irq[2]);

    // R8
    capture_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && st_q.aux_ctl.clr_on_cap && !aux_wr) |=> (aux_cnt == '0));

    // R11
    capture_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && cap_wr) |=> (st_q.caprel == $past(aux_cnt)));

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_FLAGS) |=> ((irq & $past(irq)) == $past(irq)));

endmodule

// File: tb/dtcr_top_test.sv
module dtcr_top_test;

    localparam logic [2:0] CCTL = 3'd0, ACTL = 3'd1, CCNT = 3'd2, ACNT = 3'd3, CREL = 3'd4, FLG = 3'd5;
    localparam logic [15:0] RUN = 16'h0080, DN = 16'h0020, PINEN = 16'h0040, RLD = 16'h0100;
    localparam logic [15:0] SPIN = 16'h0008, SCHAIN = 16'h0010;
    localparam logic [15:0] ERISE = 16'h0200, EFALL = 16'h0400, EBOTH = 16'h0600;
    localparam logic [15:0] CSRC = 16'h0800, CCLR = 16'h1000;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [15:0] wdata = '0, rdata;
    logic core_cnt_in = 0, core_dir_in = 0, aux_cnt_in = 0, aux_dir_in = 0;
    logic cap_in = 0, ext_cnt_in = 0, ext_dir_in = 0;
    logic tog_out, ovf_out;
    logic [2:0] irq;

    int n_tests = 0, n_fail = 0, ovf_n = 0;
    bit done = 0;

    typedef struct {
        int          kind;
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    dtcr_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .core_cnt_in(core_cnt_in), .core_dir_in(core_dir_in), .aux_cnt_in(aux_cnt_in),
        .aux_dir_in(aux_dir_in), .cap_in(cap_in), .ext_cnt_in(ext_cnt_in), .ext_dir_in(ext_dir_in),
        .tog_out(tog_out), .ovf_out(ovf_out), .irq(irq)
    );

    always @(negedge clk) if (rst_n && ovf_out) ovf_n++;

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0: act = rdata;
                    1: act = {15'd0, tog_out};
                    2: act = 16'(ovf_n);
                    default: act = {13'd0, irq};
                endcase
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int kind, input logic [15:0] e, input string tag);
        item_t it;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic exp_reg(input logic [2:0] a, input logic [15:0] e, input string tag);
        addr = a;
        push(0, e, tag);
    endtask

    function automatic logic [15:0] adv(input logic [15:0] v, input int n, input bit dn,
                                        input bit rl, input logic [15:0] rel);
        logic [15:0] x;
        x = v;
        for (int i = 0; i < n; i++) begin
            if (!dn && x == 16'hFFFF)   x = rl ? rel : 16'h0000;
            else if (dn && x == 16'h0)  x = rl ? rel : 16'hFFFF;
            else if (dn)                x = x - 16'd1;
            else                        x = x + 16'd1;
        end
        return x;
    endfunction

    // reads a start value, waits cyc cycles, expects ticks steps later
    task automatic run_chk(input logic [2:0] a, input int cyc, input int ticks, input bit dn,
                           input bit rl, input logic [15:0] rel, input string tag);
        logic [15:0] v0;
        addr = a;
        #1;
        v0 = rdata;
        repeat (cyc - 1) @(negedge clk);
        sb.push_back('{0, adv(v0, ticks, dn, rl, rel), tag});
        @(negedge clk);
        #2;
    endtask

    task automatic pin_wait();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        int base;
        logic t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        exp_reg(CCTL, 16'h0, "R12 core ctl");
        exp_reg(CCNT, 16'h0, "R12 core cnt");
        exp_reg(ACNT, 16'h0, "R12 aux cnt");
        exp_reg(CREL, 16'h0, "R12 caprel");
        exp_reg(FLG,  16'h0, "R12 flags");
        push(1, 16'h0, "R12 tog_out");

        // R1 divide by 4 and by 32
        wr(CCNT, 16'h0);
        wr(CCTL, RUN);
        run_chk(CCNT, 40, 10, 0, 0, 0, "R1 div4");
        wr(CCTL, RUN | 16'h3);
        run_chk(CCNT, 64, 2, 0, 0, 0, "R1 div32");
        wr(CCTL, 16'h0);
        run_chk(CCNT, 20, 0, 0, 0, 0, "R1 stopped holds");

        // R2 direction bit and direction pin
        wr(CCNT, 16'd100);
        wr(CCTL, RUN | DN);
        run_chk(CCNT, 20, 5, 1, 0, 0, "R2 down");
        core_dir_in = 1'b1;
        wr(CCTL, RUN | DN | PINEN);
        run_chk(CCNT, 20, 5, 0, 0, 0, "R2 pin inverts");
        wr(CCTL, RUN | DN);
        run_chk(CCNT, 20, 5, 1, 0, 0, "R2 pin ignored when disabled");
        wr(CCTL, 16'h0);
        core_dir_in = 1'b0;

        // R3 wrap going up
        wr(FLG, 16'h0);
        base = ovf_n;
        wr(CCNT, 16'hFFFE);
        wr(CCTL, RUN);
        run_chk(CCNT, 20, 5, 0, 0, 0, "R3 up wrap count");
        wr(CCTL, 16'h0);
        push(2, 16'(base + 1), "R3 ovf pulse up");
        push(1, 16'h1, "R3 toggle up");
        exp_reg(FLG, 16'h1, "R3 flag up");

        // R3 wrap going down
        wr(FLG, 16'h0);
        wr(CCNT, 16'h0001);
        wr(CCTL, RUN | DN);
        run_chk(CCNT, 20, 5, 1, 0, 0, "R3 down wrap count");
        wr(CCTL, 16'h0);
        push(2, 16'(base + 2), "R3 ovf pulse down");
        push(1, 16'h0, "R3 toggle down");

        // R10 sticky flags
        repeat (10) @(negedge clk);
        exp_reg(FLG, 16'h1, "R10 flag stays set");
        wr(FLG, 16'h1);
        exp_reg(FLG, 16'h1, "R10 writing one keeps flag");
        wr(FLG, 16'h0);
        push(3, 16'h0, "R10 writing zero clears");

        // R4 reload on wrap
        wr(CREL, 16'h1234);
        wr(CCNT, 16'hFFFE);
        wr(CCTL, RUN | RLD);
        run_chk(CCNT, 16, 4, 0, 1, 16'h1234, "R4 reload");
        wr(CCTL, 16'h0);

        // R5 chained auxiliary timer: core period of 4 ticks
        wr(CREL, 16'hFFFC);
        wr(CCNT, 16'hFFFC);
        wr(ACNT, 16'h0);
        wr(ACTL, RUN | SCHAIN);
        base = ovf_n;
        t0 = tog_out;
        wr(CCTL, RUN | RLD);
        addr = ACNT;
        repeat (63) @(negedge clk);
        sb.push_back('{0, 16'h4, "R5 aux counts core wraps"});
        @(negedge clk);
        #2;
        wr(CCTL, 16'h0);
        wr(ACTL, 16'h0);
        push(2, 16'(base + 4), "R3 four chained pulses");
        push(1, {15'd0, t0}, "R3 even toggles");

        // R6 counting pin edges
        wr(ACNT, 16'h0010);
        wr(ACTL, RUN | SPIN);
        for (int i = 0; i < 3; i++) begin
            aux_cnt_in = 1'b1; repeat (3) @(negedge clk);
            aux_cnt_in = 1'b0; repeat (3) @(negedge clk);
        end
        pin_wait();
        exp_reg(ACNT, 16'h0013, "R6 three pin edges");
        wr(ACTL, 16'h0);

        // R7 edge selection
        wr(FLG, 16'h0);
        wr(ACTL, ERISE);
        wr(ACNT, 16'h0AAA);
        cap_in = 1'b1; pin_wait();
        exp_reg(CREL, 16'h0AAA, "R7 rising capture");
        exp_reg(FLG, 16'h4, "R7 capture flag");
        wr(ACNT, 16'h0BBB);
        cap_in = 1'b0; pin_wait();
        exp_reg(CREL, 16'h0AAA, "R7 falling ignored in rising mode");
        wr(ACTL, EFALL);
        wr(ACNT, 16'h0CCC);
        cap_in = 1'b1; pin_wait();
        exp_reg(CREL, 16'h0AAA, "R7 rising ignored in falling mode");
        cap_in = 1'b0; pin_wait();
        exp_reg(CREL, 16'h0CCC, "R7 falling capture");
        wr(ACTL, EBOTH);
        wr(ACNT, 16'h0DDD);
        cap_in = 1'b1; pin_wait();
        exp_reg(CREL, 16'h0DDD, "R7 both rising");
        wr(ACNT, 16'h0EEE);
        cap_in = 1'b0; pin_wait();
        exp_reg(CREL, 16'h0EEE, "R7 both falling");
        wr(ACTL, 16'h0);
        wr(ACNT, 16'h0FFF);
        cap_in = 1'b1; pin_wait();
        exp_reg(CREL, 16'h0EEE, "R7 disabled ignores edge");

        // R8 clear after capture
        wr(ACTL, ERISE | CCLR);
        wr(ACNT, 16'h0123);
        cap_in = 1'b0; pin_wait();
        cap_in = 1'b1; pin_wait();
        exp_reg(CREL, 16'h0123, "R8 captured before clear");
        exp_reg(ACNT, 16'h0000, "R8 aux cleared");

        // R9 third-timer lines as capture source
        wr(ACTL, ERISE | CSRC);
        wr(ACNT, 16'h0321);
        ext_cnt_in = 1'b1; pin_wait();
        exp_reg(CREL, 16'h0321, "R9 count line capture");
        wr(ACNT, 16'h0432);
        ext_dir_in = 1'b1; pin_wait();
        exp_reg(CREL, 16'h0432, "R9 direction line capture");
        wr(ACNT, 16'h0543);
        cap_in = 1'b0; pin_wait();
        cap_in = 1'b1; pin_wait();
        exp_reg(CREL, 16'h0432, "R9 capture pin ignored");

        // R11 capture and software write on the same edge
        wr(ACTL, ERISE);
        cap_in = 1'b0; pin_wait();
        wr(ACNT, 16'h0555);
        cap_in = 1'b1;
        @(negedge clk);
        wr(CREL, 16'h7777);
        pin_wait();
        exp_reg(CREL, 16'h0555, "R11 capture wins");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule